// File: doc/BRIEF.md
# Indirect Control-Register Window

This block provides indirect access to a set of backing control registers at three levels: machine, supervisor and virtual-supervisor. Each level owns an eight-address window made of one selector register and six alias addresses. Software writes a value into the selector, and the aliases then reach the backing registers that this value maps to. Each alias index reaches its own register. Every level has its own mapping table, set as a compile-time parameter. A table entry gives a selector value, the alias indices that entry implements, and the minimum privilege needed to reach it.

The requester presents one access per cycle. An access carries a 12-bit register address, a write flag, write data, the current privilege and a virtualization flag. In the same cycle the block returns a window-hit flag, read data, and at most one of two exception flags: illegal-instruction or virtual-instruction. While virtualization is active, accesses to the supervisor window are redirected to the virtual-supervisor selector and its registers. A write that raises no exception takes effect at the next rising clock edge.

Top module: `csr_ind_window`

## Requirements
- R1: The window addresses are `0x350..0x357` (machine), `0x150..0x157` (supervisor) and `0x250..0x257` (virtual-supervisor), with offset 4 (`0x354`, `0x154`, `0x254`) excluded. Any other address, or an idle request, gives `rsp_hit`=0, no exception and zero read data.
- R2: After reset every selector reads zero and every backing register reads zero.
- R3: Offset 0 of a window is its selector. A write stores the low `SEL_W` bits of the write data. A read returns the stored value zero-extended.
- R4: Offsets 1,2,3,5,6,7 are alias indices 0..5. An alias access reaches the register of the lowest table entry whose selector value equals the level's current selector and whose alias mask has that index set. Distinct (entry, index) pairs are distinct registers.
- R5: With `req_virt`=1, an access to a supervisor-window address uses the virtual-supervisor selector and registers at the same offset.
- R6: Privilege codes are 0 user, 1 supervisor, 3 machine. The machine window needs privilege 3, else illegal-instruction. The supervisor window needs privilege of at least 1, else virtual-instruction if `req_virt`=1 and illegal-instruction otherwise. A direct virtual-supervisor-window access raises virtual-instruction when `req_virt`=1, and otherwise needs privilege 3, else illegal-instruction.
- R7: A redirected supervisor access (R5) is checked only against the supervisor-level rule and never against the virtual-supervisor-window rule.
- R8: An alias access that passes R6 but has no mapping under R4 raises virtual-instruction when `req_virt`=1 and illegal-instruction otherwise.
- R9: An alias access whose mapped entry has a minimum privilege above `req_priv` raises the same exception kind as R8.
- R10: An access that raises an exception returns zero read data and changes no selector and no backing register.
- R11: Read data reflects the state before the access. A non-faulting write is visible to the next access.
- R12: `rsp_illegal` and `rsp_virtual` are never both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Access present this cycle |
| req_addr | input | 12 | Control-register address |
| req_we | input | 1 | 1 = write, 0 = read |
| req_wdata | input | DW | Write data |
| req_priv | input | 2 | Current privilege (0 U, 1 S, 3 M) |
| req_virt | input | 1 | Virtualization active |
| rsp_hit | output | 1 | Address lies inside a window |
| rsp_rdata | output | DW | Read data, zero on fault or miss |
| rsp_illegal | output | 1 | Illegal-instruction exception |
| rsp_virtual | output | 1 | Virtual-instruction exception |

## Verification
The bench builds the block with its default parameters: four table entries per level, an 8-bit selector, 32-bit data, and tables that differ between levels. In those tables some entries implement only part of the alias indices, the supervisor table has one entry that needs machine privilege, and the virtual-supervisor table has one such entry. The bench programs each level's selector in turn with every table value and with two unmapped values. For each setting it writes and then reads back every window offset under all five privilege and virtualization combinations. This covers redirection, partial alias masks, entry privilege faults and both exception kinds in every level.

// File: rtl/csr_ind_pkg.sv
package csr_ind_pkg;

    localparam int NUM_ALIAS = 6;
    localparam int NUM_BANK  = 3;
    localparam int AIDX_W    = 3;

    localparam logic [1:0] PRIV_U = 2'd0;
    localparam logic [1:0] PRIV_M = 2'd3;

    typedef enum logic [1:0] {
        BANK_M  = 2'd0,
        BANK_S  = 2'd1,
        BANK_VS = 2'd2
    } bank_e;

    typedef enum logic [1:0] {
        FLT_NONE    = 2'd0,
        FLT_ILLEGAL = 2'd1,
        FLT_VIRTUAL = 2'd2
    } fault_e;

    typedef struct packed {
        logic              hit;
        bank_e             bank;
        logic              is_sel;
        logic [AIDX_W-1:0] aidx;
        fault_e            fault;
    } route_t;

    // window offset 1,2,3 -> 0,1,2 ; 5,6,7 -> 3,4,5
    function automatic logic [AIDX_W-1:0] alias_index(input logic [2:0] off);
        return (off < 3'd4) ? (off - 3'd1) : (off - 3'd2);
    endfunction

    function automatic fault_e trap_kind(input logic virt);
        return virt ? FLT_VIRTUAL : FLT_ILLEGAL;
    endfunction

endpackage

// File: rtl/csr_ind_route.sv
module csr_ind_route
    import csr_ind_pkg::*;
(
    input  logic        req_valid,
    input  logic [11:0] req_addr,
    input  logic [1:0]  req_priv,
    input  logic        req_virt,
    output route_t      route
);

    always_comb begin
        route        = '0;
        route.hit    = req_valid
                     && (req_addr[11:10] == 2'b00)
                     && (req_addr[9:8]   != 2'b00)
                     && (req_addr[7:3]   == 5'b01010)
                     && (req_addr[2:0]   != 3'd4);
        route.is_sel = (req_addr[2:0] == 3'd0);
        route.aidx   = alias_index(req_addr[2:0]);
        route.bank   = BANK_M;
        route.fault  = FLT_NONE;
        if (route.hit) begin
            case (req_addr[9:8])
                2'd3: begin
                    route.bank = BANK_M;
                    if (req_priv != PRIV_M) route.fault = FLT_ILLEGAL;
                end
                2'd1: begin
                    // redirected accesses take only the supervisor-level check
                    route.bank = req_virt ? BANK_VS : BANK_S;
                    if (req_priv == PRIV_U) route.fault = trap_kind(req_virt);
                end
                default: begin
                    route.bank = BANK_VS;
                    if (req_virt)                route.fault = FLT_VIRTUAL;
                    else if (req_priv != PRIV_M) route.fault = FLT_ILLEGAL;
                end
            endcase
        end
    end

endmodule

// File: rtl/csr_ind_bank.sv
module csr_ind_bank
    import csr_ind_pkg::*;
#(
    parameter int                              NSEL       = 4,
    parameter int                              SEL_W      = 8,
    parameter int                              DW         = 32,
    parameter logic [NSEL*SEL_W-1:0]           SEL_MAP    = '0,
    parameter logic [NSEL*NUM_ALIAS-1:0]       ALIAS_MASK = '0,
    parameter logic [NSEL*2-1:0]               MIN_PRIV   = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc,
    input  logic              is_sel,
    input  logic [AIDX_W-1:0] aidx,
    input  logic              we,
    input  logic [DW-1:0]     wdata,
    input  logic [1:0]        priv,
    input  logic              ext_fault,
    output logic [DW-1:0]     rdata,
    output logic              map_miss,
    output logic              perm_miss,
    output logic [SEL_W-1:0]  sel_o
);

    localparam int NWORD  = NSEL * NUM_ALIAS;
    localparam int ENT_W  = (NSEL > 1) ? $clog2(NSEL) : 1;
    localparam int WIDX_W = (NWORD > 1) ? $clog2(NWORD) : 1;

    typedef struct packed {
        logic [SEL_W-1:0]           sel;
        logic [NWORD-1:0][DW-1:0]   word;
    } bank_state_t;

    bank_state_t st_d, st_q;

    logic [NSEL-1:0]  ent_match;
    logic [1:0]       ent_priv [NSEL];
    logic             found;
    logic             perm_ok;
    logic [ENT_W-1:0] ent;
    logic [WIDX_W-1:0] widx;

    for (genvar e = 0; e < NSEL; e++) begin : g_ent
        logic [NUM_ALIAS-1:0] ent_mask;
        assign ent_mask     = ALIAS_MASK[e*NUM_ALIAS +: NUM_ALIAS];
        assign ent_priv[e]  = MIN_PRIV[e*2 +: 2];
        assign ent_match[e] = !is_sel
                            && (st_q.sel == SEL_MAP[e*SEL_W +: SEL_W])
                            && ent_mask[aidx];
    end

    always_comb begin
        found = 1'b0;
        ent   = '0;
        for (int e = NSEL - 1; e >= 0; e--) begin
            if (ent_match[e]) begin
                found = 1'b1;
                ent   = ENT_W'(e);
            end
        end
        widx      = WIDX_W'(int'(ent) * NUM_ALIAS + int'(aidx));
        perm_ok   = (priv >= ent_priv[ent]);
        map_miss  = !is_sel && !found;
        perm_miss = !is_sel && found && !perm_ok;

        if (is_sel)                rdata = DW'(st_q.sel);
        else if (found && perm_ok) rdata = st_q.word[widx];
        else                       rdata = '0;

        st_d = st_q;
        if (acc && we && !ext_fault) begin
            if (is_sel)                st_d.sel        = wdata[SEL_W-1:0];
            else if (found && perm_ok) st_d.word[widx] = wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sel_o = st_q.sel;

endmodule

// File: rtl/csr_ind_window.sv
module csr_ind_window
    import csr_ind_pkg::*;
#(
    parameter int                        NSEL          = 4,
    parameter int                        SEL_W         = 8,
    parameter int                        DW            = 32,
    parameter logic [NSEL*SEL_W-1:0]     M_SEL_MAP     = {8'h3F, 8'h20, 8'h05, 8'h00},
    parameter logic [NSEL*NUM_ALIAS-1:0] M_ALIAS_MASK  = {6'b111111, 6'b101010, 6'b000001, 6'b111111},
    parameter logic [NSEL*2-1:0]         M_MIN_PRIV    = {2'd3, 2'd3, 2'd3, 2'd3},
    parameter logic [NSEL*SEL_W-1:0]     S_SEL_MAP     = {8'h80, 8'h40, 8'h02, 8'h01},
    parameter logic [NSEL*NUM_ALIAS-1:0] S_ALIAS_MASK  = {6'b111111, 6'b110000, 6'b000011, 6'b111111},
    parameter logic [NSEL*2-1:0]         S_MIN_PRIV    = {2'd1, 2'd3, 2'd1, 2'd1},
    parameter logic [NSEL*SEL_W-1:0]     VS_SEL_MAP    = {8'hFF, 8'h40, 8'h07, 8'h01},
    parameter logic [NSEL*NUM_ALIAS-1:0] VS_ALIAS_MASK = {6'b011111, 6'b111111, 6'b000001, 6'b111111},
    parameter logic [NSEL*2-1:0]         VS_MIN_PRIV   = {2'd3, 2'd1, 2'd1, 2'd1}
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic [11:0]   req_addr,
    input  logic          req_we,
    input  logic [DW-1:0] req_wdata,
    input  logic [1:0]    req_priv,
    input  logic          req_virt,
    output logic          rsp_hit,
    output logic [DW-1:0] rsp_rdata,
    output logic          rsp_illegal,
    output logic          rsp_virtual
);

    localparam int MAP_W  = NSEL * SEL_W;
    localparam int MASK_W = NSEL * NUM_ALIAS;
    localparam int PRIV_W = NSEL * 2;

    localparam logic [NUM_BANK*MAP_W-1:0]  SEL_ALL  = {VS_SEL_MAP, S_SEL_MAP, M_SEL_MAP};
    localparam logic [NUM_BANK*MASK_W-1:0] MASK_ALL = {VS_ALIAS_MASK, S_ALIAS_MASK, M_ALIAS_MASK};
    localparam logic [NUM_BANK*PRIV_W-1:0] PRIV_ALL = {VS_MIN_PRIV, S_MIN_PRIV, M_MIN_PRIV};

    route_t           route;
    logic [DW-1:0]    bank_rdata    [NUM_BANK];
    logic             bank_map_miss [NUM_BANK];
    logic             bank_perm_miss[NUM_BANK];
    logic [SEL_W-1:0] bank_sel      [NUM_BANK];
    logic             addr_fault;
    fault_e           fault;
    logic [DW-1:0]    pick_rdata;
    logic             pick_miss;

    csr_ind_route u_route (
        .req_valid (req_valid),
        .req_addr  (req_addr),
        .req_priv  (req_priv),
        .req_virt  (req_virt),
        .route     (route)
    );

    assign addr_fault = (route.fault != FLT_NONE);

    for (genvar g = 0; g < NUM_BANK; g++) begin : g_bank
        csr_ind_bank #(
            .NSEL       (NSEL),
            .SEL_W      (SEL_W),
            .DW         (DW),
            .SEL_MAP    (SEL_ALL[g*MAP_W +: MAP_W]),
            .ALIAS_MASK (MASK_ALL[g*MASK_W +: MASK_W]),
            .MIN_PRIV   (PRIV_ALL[g*PRIV_W +: PRIV_W])
        ) u_bank (
            .clk       (clk),
            .rst_n     (rst_n),
            .acc       (route.hit && (route.bank == bank_e'(g))),
            .is_sel    (route.is_sel),
            .aidx      (route.aidx),
            .we        (req_we),
            .wdata     (req_wdata),
            .priv      (req_priv),
            .ext_fault (addr_fault),
            .rdata     (bank_rdata[g]),
            .map_miss  (bank_map_miss[g]),
            .perm_miss (bank_perm_miss[g]),
            .sel_o     (bank_sel[g])
        );
    end

    always_comb begin
        pick_rdata = '0;
        pick_miss  = 1'b0;
        for (int b = 0; b < NUM_BANK; b++) begin
            if (route.bank == bank_e'(b)) begin
                pick_rdata = bank_rdata[b];
                pick_miss  = bank_map_miss[b] || bank_perm_miss[b];
            end
        end
        fault = route.fault;
        if (route.hit && (fault == FLT_NONE) && pick_miss) fault = trap_kind(req_virt);
    end

    assign rsp_hit     = route.hit;
    assign rsp_illegal = (fault == FLT_ILLEGAL);
    assign rsp_virtual = (fault == FLT_VIRTUAL);
    assign rsp_rdata   = (route.hit && (fault == FLT_NONE)) ? pick_rdata : '0;

endmodule

// File: rtl/csr_ind_window_chk.sv
module csr_ind_window_chk #(
    parameter int DW    = 32,
    parameter int SEL_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic [11:0]      req_addr,
    input logic             req_we,
    input logic [DW-1:0]    req_wdata,
    input logic [1:0]       req_priv,
    input logic             req_virt,
    input logic             rsp_hit,
    input logic [DW-1:0]    rsp_rdata,
    input logic             rsp_illegal,
    input logic             rsp_virtual,
    input logic [SEL_W-1:0] sel_m
);

    // R12
    one_trap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(rsp_illegal && rsp_virtual));

    // R10
    trap_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_illegal || rsp_virtual) |-> (rsp_rdata == '0));

    // R1
    miss_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_hit |-> (!rsp_illegal && !rsp_virtual && rsp_rdata == '0));

    // R6
    m_priv_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && rsp_hit && req_addr[9:8] == 2'd3 && req_priv != 2'd3) |-> rsp_illegal);

    // R6
    vs_direct_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && rsp_hit && req_addr[9:8] == 2'd2 && req_virt) |-> rsp_virtual);

    // R11
    sel_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_we && req_addr == 12'h350 && !rsp_illegal && !rsp_virtual)
        |=> (sel_m == $past(req_wdata[SEL_W-1:0])));

    // R10
    sel_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_addr == 12'h350 && rsp_illegal) |=> $stable(sel_m));

endmodule

bind csr_ind_window csr_ind_window_chk #(.DW(DW), .SEL_W(SEL_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_addr    (req_addr),
    .req_we      (req_we),
    .req_wdata   (req_wdata),
    .req_priv    (req_priv),
    .req_virt    (req_virt),
    .rsp_hit     (rsp_hit),
    .rsp_rdata   (rsp_rdata),
    .rsp_illegal (rsp_illegal),
    .rsp_virtual (rsp_virtual),
    .sel_m       (bank_sel[0])
);

// File: tb/csr_ind_window_bench.sv
`timescale 1ns/1ps
module csr_ind_window_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [11:0] req_addr = '0;
    logic        req_we = 1'b0;
    logic [31:0] req_wdata = '0;
    logic [1:0]  req_priv = '0;
    logic        req_virt = 1'b0;
    logic        rsp_hit;
    logic [31:0] rsp_rdata;
    logic        rsp_illegal;
    logic        rsp_virtual;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;
    int stamp = 0;

    always #10 clk = ~clk;

    csr_ind_window u_csr_ind_window (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid   (req_valid),
        .req_addr    (req_addr),
        .req_we      (req_we),
        .req_wdata   (req_wdata),
        .req_priv    (req_priv),
        .req_virt    (req_virt),
        .rsp_hit     (rsp_hit),
        .rsp_rdata   (rsp_rdata),
        .rsp_illegal (rsp_illegal),
        .rsp_virtual (rsp_virtual)
    );

    // expected tables, entry 0 first: bank 0 machine, 1 supervisor, 2 virtual-supervisor
    localparam int TB_SEL [3][4] = '{'{8'h00, 8'h05, 8'h20, 8'h3F},
                                     '{8'h01, 8'h02, 8'h40, 8'h80},
                                     '{8'h01, 8'h07, 8'h40, 8'hFF}};
    localparam logic [5:0] TB_MASK [3][4] = '{'{6'b111111, 6'b000001, 6'b101010, 6'b111111},
                                              '{6'b111111, 6'b000011, 6'b110000, 6'b111111},
                                              '{6'b111111, 6'b000001, 6'b111111, 6'b011111}};
    localparam int TB_PRIV [3][4] = '{'{3, 3, 3, 3}, '{1, 1, 3, 1}, '{1, 1, 1, 3}};

    int          mdl_sel [3];
    logic [31:0] mdl_mem [3][4][6];

    task automatic access(input logic [11:0] a, input logic we, input logic [31:0] wd,
                          input int pr, input logic vt, input string force_tag);
        logic eh, e_ill, e_vir, commit;
        logic [31:0] erd;
        int lvl, off, bk, ai, ent;
        string tag;
        @(negedge clk);
        req_valid = 1'b1; req_addr = a; req_we = we; req_wdata = wd;
        req_priv = 2'(pr); req_virt = vt;
        #5;
        eh = (a[11:10] == 2'b00) && (a[9:8] != 2'b00) && (a[7:3] == 5'b01010) && (a[2:0] != 3'd4);
        e_ill = 0; e_vir = 0; commit = 0; erd = '0; tag = "R1";
        bk = 0; ai = 0; ent = -1; off = 0;
        if (eh) begin
            lvl = int'(a[9:8]); off = int'(a[2:0]);
            bk = (lvl == 3) ? 0 : ((lvl == 1) ? (vt ? 2 : 1) : 2);
            tag = (lvl == 1 && vt) ? "R5/R7" : ((off == 0) ? "R3" : "R4");
            if (lvl == 3 && pr != 3) begin e_ill = 1; tag = "R6"; end
            else if (lvl == 1 && pr == 0) begin e_ill = !vt; e_vir = vt; tag = "R6"; end
            else if (lvl == 2 && vt) begin e_vir = 1; tag = "R6"; end
            else if (lvl == 2 && pr != 3) begin e_ill = 1; tag = "R6"; end
            else if (off == 0) begin erd = 32'(mdl_sel[bk]); commit = we; end
            else begin
                ai = (off < 4) ? off - 1 : off - 2;
                for (int e = 0; e < 4; e++)
                    if (ent < 0 && TB_SEL[bk][e] == mdl_sel[bk] && TB_MASK[bk][e][ai]) ent = e;
                if (ent < 0) begin e_ill = !vt; e_vir = vt; tag = "R8"; end
                else if (pr < TB_PRIV[bk][ent]) begin e_ill = !vt; e_vir = vt; tag = "R9"; end
                else begin erd = mdl_mem[bk][ent][ai]; commit = we; end
            end
        end
        if (e_ill || e_vir) tag = {tag, " R10 R12"};
        if (commit) tag = {tag, " R11"};
        if (force_tag != "") tag = force_tag;
        checks++;
        if ({rsp_hit, rsp_illegal, rsp_virtual, rsp_rdata} != {eh, e_ill, e_vir, erd}) begin
            failures++;
            $display("FAIL %s addr=%h we=%0d priv=%0d virt=%0d: got hit=%0d ill=%0d vir=%0d rd=%h, expected hit=%0d ill=%0d vir=%0d rd=%h",
                     tag, a, we, pr, vt, rsp_hit, rsp_illegal, rsp_virtual, rsp_rdata,
                     eh, e_ill, e_vir, erd);
        end
        @(posedge clk);
        #1;
        req_valid = 1'b0;
        if (commit) begin
            if (off == 0) mdl_sel[bk] = int'(wd[7:0]);
            else          mdl_mem[bk][ent][ai] = wd;
        end
    endtask

    initial begin
        #3000000;
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        for (int b = 0; b < 3; b++) begin
            mdl_sel[b] = 0;
            for (int e = 0; e < 4; e++)
                for (int i = 0; i < 6; i++) mdl_mem[b][e][i] = '0;
        end
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;

        // R2: reset state of selectors and a mapped register
        access(12'h350, 0, '0, 3, 0, "R2");
        access(12'h150, 0, '0, 3, 0, "R2");
        access(12'h250, 0, '0, 3, 0, "R2");
        access(12'h351, 0, '0, 3, 0, "R2");
        access(12'h357, 0, '0, 3, 0, "R2");

        // R1: addresses outside the windows
        access(12'h354, 1, 32'hDEAD_BEEF, 3, 0, "R1");
        access(12'h154, 0, '0, 1, 0, "R1");
        access(12'h254, 0, '0, 3, 0, "R1");
        access(12'h34F, 0, '0, 3, 0, "R1");
        access(12'h358, 0, '0, 3, 0, "R1");
        access(12'h050, 0, '0, 3, 0, "R1");
        access(12'h750, 0, '0, 3, 0, "R1");
        access(12'h350, 0, '0, 3, 0, "R1");

        // sweep every level, selector value, offset and privilege/virt pairing
        for (int L = 0; L < 3; L++) begin
            for (int s = 0; s < 6; s++) begin
                logic [11:0] base;
                int sv;
                base = (L == 0) ? 12'h350 : ((L == 1) ? 12'h150 : 12'h250);
                sv = (s < 4) ? TB_SEL[L][s] : ((s == 4) ? ((L == 0) ? 1 : 0) : 8'hAA);
                access(base, 1, {24'hABCDEF, 8'(sv)}, 3, 0, "");
                for (int m = 0; m < 5; m++) begin
                    int pv;
                    logic vt;
                    pv = (m < 2) ? 0 : ((m < 4) ? 1 : 3);
                    vt = (m == 1 || m == 3);
                    for (int off = 0; off < 8; off++) begin
                        if (off == 4) continue;
                        if (off != 0) begin
                            stamp++;
                            access(base | 12'(off), 1,
                                   {8'(L), 8'(sv), 4'(off), 4'(m), 8'(stamp)}, pv, vt, "");
                        end
                        access(base | 12'(off), 0, '0, pv, vt, "");
                    end
                end
            end
        end

        // R10: faulting selector write leaves state unchanged
        access(12'h350, 1, 32'h0000_0005, 1, 0, "");
        access(12'h350, 0, '0, 3, 0, "R10");

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule